// File: doc/BRIEF.md
# 24-bit Accumulator Processor Core

A compact multicycle processor built around one accumulator. Its data words are 24 bits wide and its memory is addressed by byte. Besides the accumulator it holds an index register, a link register, a program counter and a condition code that reads less, equal or greater. Every instruction is three bytes long and is fetched one byte at a time. The core then decodes an 8-bit opcode and runs the operation. The operations are word and byte loads and stores, add, subtract, multiply, divide, AND, OR, compare, conditional and unconditional branches, subroutine call and return, and byte-wide device transfers.

The core talks to a synchronous single-port byte memory. Read data appears one cycle after the address is presented, and a write takes effect at the clock edge while the write enable is high. A small device port carries a device number, a ready input, read and write strobes and a byte in each direction. When an opcode is not recognised, the core raises `halt` and stays idle until reset. A divide by zero sets a sticky error flag.

Top module: `acc24_core`

## Requirements
- R1: An instruction is three big-endian bytes read from PC, PC+1 and PC+2. Bits 23:16 hold the opcode, bit 15 is an index flag and bits 14:0 hold an address. When the flag is 1, the effective address m is that address plus the low 15 bits of the index register, modulo 2^15. The core issues each memory read as an address in one cycle and takes `mem_rdata` in the next cycle.
- R2: Opcode 0x00 loads the accumulator, 0x04 the index register and 0x08 the link register. Each load takes the 24-bit word at m..m+2, and the byte at m is the most significant.
- R3: Opcode 0x0C stores the accumulator, 0x14 the index register and 0x10 the link register. Each store writes exactly three bytes to m..m+2, most significant byte first.
- R4: Opcode 0x50 replaces bits 7:0 of the accumulator with the byte at m and leaves bits 23:8 unchanged. Opcode 0x54 writes bits 7:0 of the accumulator to address m and writes no other byte.
- R5: Opcodes 0x18, 0x1C and 0x20 put the low 24 bits of A+w, A−w and A×w into the accumulator, where w is the word at m.
- R6: Opcode 0x24 puts the signed quotient A÷w into the accumulator, truncated toward zero. When w is zero, the accumulator keeps its value and `div_err` goes high and stays high until reset.
- R7: Opcodes 0x40 and 0x44 put A AND w and A OR w into the accumulator.
- R8: Opcode 0x28 compares A with w as signed numbers. It sets the condition code to less, equal or greater and leaves the accumulator unchanged.
- R9: Opcode 0x3C always branches to m. Opcodes 0x30, 0x34 and 0x38 branch to m only when the condition code is equal, greater or less. When no branch is taken, execution goes on at the next instruction.
- R10: Opcode 0x48 writes the address of the next instruction (its own address plus 3) into the link register and branches to m. Opcode 0x4C sets the PC to the low 15 bits of the link register.
- R11: Opcodes 0xE0, 0xD8 and 0xDC address the device whose number is the byte at m, presented on `dev_id`. Opcode 0xE0 sets the condition code to less when `dev_ready` is 1 and to equal otherwise. Opcode 0xD8 pulses `dev_rd` for one cycle and loads `dev_rdata` into bits 7:0 of the accumulator. Opcode 0xDC pulses `dev_wr` for one cycle with bits 7:0 of the accumulator on `dev_wdata`.
- R12: An opcode not listed above raises `halt`. From then on `halt` stays high and the core makes no memory write and no device strobe until reset.
- R13: After reset, `halt` and `div_err` are low and fetching starts at address 0. A, X and L are zero and the condition code is equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | AW (15) | Byte address to memory |
| mem_wdata | output | 8 | Byte to write |
| mem_we | output | 1 | Write enable |
| mem_rdata | input | 8 | Byte read, valid the cycle after the address |
| dev_id | output | 8 | Selected device number |
| dev_ready | input | 1 | Device ready status |
| dev_rd | output | 1 | One-cycle device read strobe |
| dev_wr | output | 1 | One-cycle device write strobe |
| dev_wdata | output | 8 | Byte sent to the device |
| dev_rdata | input | 8 | Byte returned by the device |
| halt | output | 1 | Core stopped on an unknown opcode |
| div_err | output | 1 | Sticky divide-by-zero flag |

## Verification
The core keeps most of its state inside, so a wrong register or condition code first shows up as a wrong byte written to memory. A stored word, a marker byte chosen by a conditional branch or a device strobe with the wrong byte can reveal it within a few instructions. The test programs therefore copy every register to memory soon after changing it, and they route each comparison outcome through a branch that leaves a distinct marker. Errors in sequencing show at once as extra or missing memory writes or strobes. They also show as a `halt` that comes too early, never comes, or drops again.

// File: rtl/acc24_pkg.sv
package acc24_pkg;

   localparam logic [7:0] OPC_LOAD_A   = 8'h00;
   localparam logic [7:0] OPC_LOAD_X   = 8'h04;
   localparam logic [7:0] OPC_LOAD_L   = 8'h08;
   localparam logic [7:0] OPC_STORE_A  = 8'h0C;
   localparam logic [7:0] OPC_STORE_L  = 8'h10;
   localparam logic [7:0] OPC_STORE_X  = 8'h14;
   localparam logic [7:0] OPC_ADD      = 8'h18;
   localparam logic [7:0] OPC_SUB      = 8'h1C;
   localparam logic [7:0] OPC_MUL      = 8'h20;
   localparam logic [7:0] OPC_DIV      = 8'h24;
   localparam logic [7:0] OPC_CMP      = 8'h28;
   localparam logic [7:0] OPC_BR_EQ    = 8'h30;
   localparam logic [7:0] OPC_BR_GT    = 8'h34;
   localparam logic [7:0] OPC_BR_LT    = 8'h38;
   localparam logic [7:0] OPC_BR       = 8'h3C;
   localparam logic [7:0] OPC_AND      = 8'h40;
   localparam logic [7:0] OPC_OR       = 8'h44;
   localparam logic [7:0] OPC_CALL     = 8'h48;
   localparam logic [7:0] OPC_RET      = 8'h4C;
   localparam logic [7:0] OPC_LOAD_B   = 8'h50;
   localparam logic [7:0] OPC_STORE_B  = 8'h54;
   localparam logic [7:0] OPC_DEV_IN   = 8'hD8;
   localparam logic [7:0] OPC_DEV_OUT  = 8'hDC;
   localparam logic [7:0] OPC_DEV_TEST = 8'hE0;

   typedef enum logic [1:0] {CC_EQ = 2'd0, CC_LT = 2'd1, CC_GT = 2'd2} cc_e;

   typedef enum logic [2:0] {
      ALU_ADD, ALU_SUB, ALU_MUL, ALU_DIV, ALU_AND, ALU_OR
   } alu_op_e;

   typedef enum logic [1:0] {CL_READ, CL_WRITE, CL_BRANCH, CL_BAD} cls_e;

   typedef enum logic [2:0] {
      S_FA, S_FD, S_DEC, S_RA, S_RD, S_EX, S_WR, S_HALT
   } state_e;

endpackage

// File: rtl/acc24_dec.sv
module acc24_dec
   import acc24_pkg::*;
(
   input  logic [7:0] op,
   output cls_e       cls,
   output logic       one_byte,
   output logic       is_alu,
   output alu_op_e    alu_op
);

   always_comb begin
      cls      = CL_BAD;
      one_byte = 1'b0;
      is_alu   = 1'b0;
      alu_op   = ALU_ADD;
      case (op)
         OPC_LOAD_A, OPC_LOAD_X, OPC_LOAD_L, OPC_CMP: cls = CL_READ;
         OPC_ADD: begin cls = CL_READ; is_alu = 1'b1; alu_op = ALU_ADD; end
         OPC_SUB: begin cls = CL_READ; is_alu = 1'b1; alu_op = ALU_SUB; end
         OPC_MUL: begin cls = CL_READ; is_alu = 1'b1; alu_op = ALU_MUL; end
         OPC_DIV: begin cls = CL_READ; is_alu = 1'b1; alu_op = ALU_DIV; end
         OPC_AND: begin cls = CL_READ; is_alu = 1'b1; alu_op = ALU_AND; end
         OPC_OR:  begin cls = CL_READ; is_alu = 1'b1; alu_op = ALU_OR;  end
         OPC_LOAD_B, OPC_DEV_IN, OPC_DEV_OUT, OPC_DEV_TEST: begin
            cls      = CL_READ;
            one_byte = 1'b1;
         end
         OPC_STORE_A, OPC_STORE_X, OPC_STORE_L: cls = CL_WRITE;
         OPC_STORE_B: begin cls = CL_WRITE; one_byte = 1'b1; end
         OPC_BR, OPC_BR_EQ, OPC_BR_GT, OPC_BR_LT, OPC_CALL, OPC_RET:
            cls = CL_BRANCH;
         default: cls = CL_BAD;
      endcase
   end

endmodule

// File: rtl/acc24_alu.sv
module acc24_alu
   import acc24_pkg::*;
#(
   parameter int DW = 24
) (
   input  alu_op_e        op,
   input  logic [DW-1:0]  a,
   input  logic [DW-1:0]  b,
   output logic [DW-1:0]  y,
   output logic           dz
);

   logic signed [DW-1:0] sa, sb, quo;

   assign sa  = a;
   assign sb  = b;
   assign dz  = (b == '0);
   assign quo = dz ? sa : (sa / sb);

   always_comb begin
      case (op)
         ALU_ADD: y = a + b;
         ALU_SUB: y = a - b;
         ALU_MUL: y = a * b;
         ALU_DIV: y = quo;
         ALU_AND: y = a & b;
         default: y = a | b;
      endcase
   end

endmodule

// File: rtl/acc24_cmp.sv
module acc24_cmp
   import acc24_pkg::*;
#(
   parameter int DW = 24
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   output cc_e           cc
);

   logic lt, gt, eq;

   assign lt = $signed(a) < $signed(b);
   assign gt = $signed(a) > $signed(b);
   assign eq = (a == b);
   assign cc = lt ? CC_LT : (gt ? CC_GT : CC_EQ);

   always_comb begin
      if (!$isunknown({a, b})) begin
         // R8
         cmp_onehot_chk: assert ($onehot({lt, eq, gt}));
      end
   end

endmodule

// File: rtl/acc24_core.sv
module acc24_core
   import acc24_pkg::*;
#(
   parameter int AW = 15,
   parameter int DW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [AW-1:0] mem_addr,
   output logic [7:0]    mem_wdata,
   output logic          mem_we,
   input  logic [7:0]    mem_rdata,
   output logic [7:0]    dev_id,
   input  logic          dev_ready,
   output logic          dev_rd,
   output logic          dev_wr,
   output logic [7:0]    dev_wdata,
   input  logic [7:0]    dev_rdata,
   output logic          halt,
   output logic          div_err
);

   localparam int NB   = DW / 8;
   localparam int MAXB = (NB > 3) ? NB : 3;
   localparam int CW   = $clog2(MAXB);

   generate
      if ((DW % 8) != 0 || DW < 16 || DW > 32) begin : g_bad_dw
         $error("acc24_core: DW must be 16, 24 or 32");
      end
      if (AW < 8 || AW > 15 || AW > DW) begin : g_bad_aw
         $error("acc24_core: AW must lie in 8..15 and not exceed DW");
      end
   endgenerate

   state_e          state_q;
   logic [CW-1:0]   cnt_q, nb_q;
   logic [23:0]     ir_q;
   logic [AW-1:0]   pc_q, ea_q;
   logic [DW-1:0]   acc_q, idx_q, lnk_q, opnd_q, wbuf_q;
   cc_e             cc_q;
   logic            err_q;

   logic [7:0]      op;
   cls_e            cls;
   logic            one_byte, is_alu, dz, take;
   alu_op_e         alu_op;
   logic [DW-1:0]   alu_y;
   cc_e             cmp_cc;
   logic [AW-1:0]   ea_n, pc_n;

   assign op   = ir_q[23:16];
   assign ea_n = ir_q[AW-1:0] + (ir_q[15] ? idx_q[AW-1:0] : '0);
   assign pc_n = pc_q + AW'(3);

   acc24_dec u_dec (
      .op       (op),
      .cls      (cls),
      .one_byte (one_byte),
      .is_alu   (is_alu),
      .alu_op   (alu_op)
   );

   acc24_alu #(.DW(DW)) u_alu (
      .op (alu_op),
      .a  (acc_q),
      .b  (opnd_q),
      .y  (alu_y),
      .dz (dz)
   );

   acc24_cmp #(.DW(DW)) u_cmp (
      .a  (acc_q),
      .b  (opnd_q),
      .cc (cmp_cc)
   );

   always_comb begin
      case (op)
         OPC_BR:    take = 1'b1;
         OPC_BR_EQ: take = (cc_q == CC_EQ);
         OPC_BR_GT: take = (cc_q == CC_GT);
         OPC_BR_LT: take = (cc_q == CC_LT);
         default:   take = 1'b0;
      endcase
   end

   always_comb begin
      case (state_q)
         S_FA:       mem_addr = pc_q + AW'(cnt_q);
         S_RA, S_WR: mem_addr = ea_q + AW'(cnt_q);
         default:    mem_addr = pc_q;
      endcase
   end

   assign mem_we    = (state_q == S_WR);
   assign mem_wdata = wbuf_q[DW-1 -: 8];
   assign dev_id    = (state_q == S_EX) ? opnd_q[7:0] : 8'h00;
   assign dev_rd    = (state_q == S_EX) && (op == OPC_DEV_IN);
   assign dev_wr    = (state_q == S_EX) && (op == OPC_DEV_OUT);
   assign dev_wdata = acc_q[7:0];
   assign halt      = (state_q == S_HALT);
   assign div_err   = err_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_FA;
         cnt_q   <= '0;
         nb_q    <= '0;
         ir_q    <= '0;
         pc_q    <= '0;
         ea_q    <= '0;
         acc_q   <= '0;
         idx_q   <= '0;
         lnk_q   <= '0;
         opnd_q  <= '0;
         wbuf_q  <= '0;
         cc_q    <= CC_EQ;
         err_q   <= 1'b0;
      end else begin
         case (state_q)
            S_FA: state_q <= S_FD;
            S_FD: begin
               ir_q <= {ir_q[15:0], mem_rdata};
               if (cnt_q == CW'(2)) begin
                  cnt_q   <= '0;
                  state_q <= S_DEC;
               end else begin
                  cnt_q   <= cnt_q + 1'b1;
                  state_q <= S_FA;
               end
            end
            S_DEC: begin
               ea_q   <= ea_n;
               pc_q   <= pc_n;
               opnd_q <= '0;
               cnt_q  <= '0;
               nb_q   <= one_byte ? '0 : CW'(NB - 1);
               case (cls)
                  CL_READ:  state_q <= S_RA;
                  CL_WRITE: begin
                     case (op)
                        OPC_STORE_A: wbuf_q <= acc_q;
                        OPC_STORE_X: wbuf_q <= idx_q;
                        OPC_STORE_L: wbuf_q <= lnk_q;
                        default:     wbuf_q <= {acc_q[7:0], {(DW-8){1'b0}}};
                     endcase
                     state_q <= S_WR;
                  end
                  CL_BRANCH: begin
                     state_q <= S_FA;
                     if (op == OPC_CALL) begin
                        lnk_q <= DW'(pc_n);
                        pc_q  <= ea_n;
                     end else if (op == OPC_RET) begin
                        pc_q <= lnk_q[AW-1:0];
                     end else if (take) begin
                        pc_q <= ea_n;
                     end
                  end
                  default: state_q <= S_HALT;
               endcase
            end
            S_RA: state_q <= S_RD;
            S_RD: begin
               opnd_q <= {opnd_q[DW-9:0], mem_rdata};
               if (cnt_q == nb_q) begin
                  state_q <= S_EX;
               end else begin
                  cnt_q   <= cnt_q + 1'b1;
                  state_q <= S_RA;
               end
            end
            S_EX: begin
               cnt_q   <= '0;
               state_q <= S_FA;
               case (op)
                  OPC_LOAD_A:   acc_q <= opnd_q;
                  OPC_LOAD_X:   idx_q <= opnd_q;
                  OPC_LOAD_L:   lnk_q <= opnd_q;
                  OPC_LOAD_B:   acc_q[7:0] <= opnd_q[7:0];
                  OPC_CMP:      cc_q <= cmp_cc;
                  OPC_DEV_TEST: cc_q <= dev_ready ? CC_LT : CC_EQ;
                  OPC_DEV_IN:   acc_q[7:0] <= dev_rdata;
                  default: begin
                     if (is_alu) begin
                        if (alu_op == ALU_DIV && dz) err_q <= 1'b1;
                        else                         acc_q <= alu_y;
                     end
                  end
               endcase
            end
            S_WR: begin
               wbuf_q <= wbuf_q << 8;
               if (cnt_q == nb_q) begin
                  cnt_q   <= '0;
                  state_q <= S_FA;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: state_q <= S_HALT;
         endcase
      end
   end

   // R12
   halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> halt);

   // R12
   halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halt |-> (!mem_we && !dev_rd && !dev_wr));

   // R6
   div_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(div_err) |-> $stable(acc_q));

   // R11
   strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_rd || dev_wr) |=> !(dev_rd || dev_wr));

   // R10
   ret_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_DEC && op == OPC_RET) |=> (pc_q == $past(lnk_q[AW-1:0])));

endmodule

// File: tb/tb_acc24_core.sv
`timescale 1ns/1ps
module tb_acc24_core;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [14:0] mem_addr;
   logic [7:0]  mem_wdata, mem_rdata, dev_id, dev_wdata;
   logic        mem_we, dev_ready, dev_rd, dev_wr, halt, div_err;
   logic [7:0]  dev_rdata = 8'h3C;

   logic [7:0]  mem [0:4095];
   int          nchk = 0, nerr = 0;
   int          rd_cnt, wr_cnt;
   logic [7:0]  rd_id, wr_byte;

   always #4 clk = ~clk;

   acc24_core dut (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_we(mem_we), .mem_rdata(mem_rdata), .dev_id(dev_id),
      .dev_ready(dev_ready), .dev_rd(dev_rd), .dev_wr(dev_wr),
      .dev_wdata(dev_wdata), .dev_rdata(dev_rdata), .halt(halt),
      .div_err(div_err)
   );

   always @(posedge clk) begin
      if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[11:0]];
   end

   always @(posedge clk) begin
      if (rst_n && dev_rd) begin rd_cnt <= rd_cnt + 1; rd_id <= dev_id; end
      if (rst_n && dev_wr) begin wr_cnt <= wr_cnt + 1; wr_byte <= dev_wdata; end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
   endtask

   task automatic put_ins(input int ad, input logic [7:0] op, input logic x, input int m);
      mem[ad]   = op;
      mem[ad+1] = {x, m[14:8]};
      mem[ad+2] = m[7:0];
   endtask

   task automatic put_word(input int ad, input logic [23:0] v);
      mem[ad] = v[23:16]; mem[ad+1] = v[15:8]; mem[ad+2] = v[7:0];
   endtask

   function automatic logic [23:0] get_word(input int ad);
      return {mem[ad], mem[ad+1], mem[ad+2]};
   endfunction

   function automatic logic [23:0] f_alu(input logic [7:0] op, input logic [23:0] a,
                                         input logic [23:0] b);
      logic signed [23:0] sa, sb;
      sa = a; sb = b;
      case (op)
         8'h18: return a + b;
         8'h1C: return a - b;
         8'h20: return a * b;
         8'h24: return (b == 24'h0) ? a : 24'(sa / sb);
         8'h40: return a & b;
         default: return a | b;
      endcase
   endfunction

   task automatic hold_reset();
      rst_n = 1'b0;
      rd_cnt = 0; wr_cnt = 0; rd_id = 8'h00; wr_byte = 8'h00;
      repeat (2) @(negedge clk);
   endtask

   task automatic run_prog(input string req);
      int cyc;
      repeat (1) @(negedge clk);
      rst_n = 1'b1;
      cyc = 0;
      while (!halt && cyc < 6000) begin
         @(negedge clk);
         cyc++;
      end
      chk({req, " halt reached"}, {31'd0, halt}, 32'd1);
   endtask

   task automatic alu_case(input logic [7:0] op, input logic [23:0] a, input logic [23:0] b);
      logic [23:0] res;
      logic [7:0]  mark;
      logic        dz;
      hold_reset();
      clear_mem();
      put_ins(0, 8'h00, 0, 'h200);
      put_ins(3, op, 0, 'h203);
      put_ins(6, 8'h0C, 0, 'h206);
      put_ins(9, 8'h28, 0, 'h203);
      put_ins(12, 8'h38, 0, 24);
      put_ins(15, 8'h30, 0, 36);
      put_ins(18, 8'h34, 0, 48);
      mem[21] = 8'hFF;
      for (int k = 0; k < 3; k++) begin
         put_ins(24 + 12*k, 8'h50, 0, 'h300 + k);
         put_ins(27 + 12*k, 8'h0C, 0, 'h20C);
         put_ins(30 + 12*k, 8'h54, 0, 'h209);
         mem[33 + 12*k] = 8'hFF;
      end
      put_word('h200, a);
      put_word('h203, b);
      mem['h20A] = 8'hEE;
      mem['h300] = 8'h01; mem['h301] = 8'h02; mem['h302] = 8'h03;
      run_prog("R12");
      dz  = (op == 8'h24) && (b == 24'h0);
      res = f_alu(op, a, b);
      if ($signed(res) < $signed(b))      mark = 8'h01;
      else if (res == b)                  mark = 8'h02;
      else                                mark = 8'h03;
      case (op)
         8'h24:        chk("R6 quotient word", {8'h0, get_word('h206)}, {8'h0, res});
         8'h40, 8'h44: chk("R7 logic word", {8'h0, get_word('h206)}, {8'h0, res});
         default:      chk("R5 arith word", {8'h0, get_word('h206)}, {8'h0, res});
      endcase
      chk("R8 R9 compare branch marker", {24'h0, mem['h209]}, {24'h0, mark});
      chk("R4 byte load keeps upper bits", {8'h0, get_word('h20C)}, {8'h0, res[23:8], mark});
      chk("R4 byte store touches one byte", {24'h0, mem['h20A]}, 32'hEE);
      if (op == 8'h24)
         chk("R6 divide error flag", {31'd0, div_err}, {31'd0, dz});
   endtask

   initial begin
      int unsigned sd;
      logic [7:0]  ops [6];
      logic [23:0] a, b;
      sd = $urandom(32'd4242);
      ops[0] = 8'h18; ops[1] = 8'h1C; ops[2] = 8'h20;
      ops[3] = 8'h24; ops[4] = 8'h40; ops[5] = 8'h44;
      dev_ready = 1'b0;

      // R13 reset state at the ports
      hold_reset();
      chk("R13 halt low in reset", {31'd0, halt}, 32'd0);
      chk("R13 div_err low in reset", {31'd0, div_err}, 32'd0);
      chk("R13 no write in reset", {31'd0, mem_we}, 32'd0);
      chk("R13 first fetch address", {17'd0, mem_addr}, 32'd0);

      // directed arithmetic corners
      alu_case(8'h24, -24'sd7, 24'sd2);
      alu_case(8'h24, 24'sd7, -24'sd2);
      alu_case(8'h24, 24'h800000, 24'hFFFFFF);
      alu_case(8'h24, 24'h000005, 24'h000000);
      alu_case(8'h1C, 24'h000005, 24'h000005);
      alu_case(8'h18, 24'h7FFFFF, 24'h000001);
      alu_case(8'h20, 24'hFFFFFF, 24'hFFFFFF);

      // constrained random arithmetic and logic
      for (int t = 0; t < 48; t++) begin
         int sel;
         a = 24'($urandom);
         sel = int'($urandom % 8);
         case (sel)
            0: b = a;
            1: b = 24'h0;
            2: b = 24'($signed(8'($urandom)));
            3: a = 24'($signed(8'($urandom)));
            default: b = 24'($urandom);
         endcase
         if (sel == 3) b = 24'($urandom % 16) + 24'd1;
         alu_case(ops[t % 6], a, b);
      end

      // program 2: index, register stores, call/return, devices
      hold_reset();
      clear_mem();
      dev_ready = 1'b1;
      put_ins(0,  8'h04, 0, 'h210);
      put_ins(3,  8'h00, 1, 'h213);
      put_ins(6,  8'h0C, 0, 'h220);
      put_ins(9,  8'h48, 0, 42);
      put_ins(12, 8'h10, 0, 'h223);
      put_ins(15, 8'hE0, 0, 'h230);
      put_ins(18, 8'h38, 0, 24);
      mem[21] = 8'hFF;
      put_ins(24, 8'hD8, 0, 'h230);
      put_ins(27, 8'hDC, 0, 'h230);
      put_ins(30, 8'h0C, 0, 'h226);
      put_ins(33, 8'h08, 0, 'h240);
      put_ins(36, 8'h10, 0, 'h243);
      mem[39] = 8'hFF;
      put_ins(42, 8'h14, 0, 'h229);
      put_ins(45, 8'h4C, 0, 0);
      put_word('h210, 24'h000003);
      put_word('h216, 24'hA1B2C3);
      mem['h230] = 8'h5A;
      put_word('h240, 24'h123456);
      run_prog("R12");
      chk("R1 R2 indexed word load", {8'h0, get_word('h220)}, 32'hA1B2C3);
      chk("R10 link holds return address", {8'h0, get_word('h223)}, 32'h00000C);
      chk("R3 R2 index store", {8'h0, get_word('h229)}, 32'h000003);
      chk("R11 device byte into accumulator", {8'h0, get_word('h226)}, 32'hA1B23C);
      chk("R2 R3 link load and store", {8'h0, get_word('h243)}, 32'h123456);
      chk("R11 read strobe count", rd_cnt, 32'd1);
      chk("R11 device id", {24'h0, rd_id}, 32'h5A);
      chk("R11 write strobe count", wr_cnt, 32'd1);
      chk("R11 device write byte", {24'h0, wr_byte}, 32'h3C);

      // program 3: reset registers, device busy, unconditional branch, halt
      hold_reset();
      clear_mem();
      dev_ready = 1'b0;
      put_ins(0,  8'h30, 0, 6);
      mem[3] = 8'hFF;
      put_ins(6,  8'h0C, 0, 'h260);
      put_ins(9,  8'hE0, 0, 'h230);
      put_ins(12, 8'h30, 0, 18);
      mem[15] = 8'hFF;
      put_ins(18, 8'h3C, 0, 24);
      mem[21] = 8'hFF;
      put_ins(24, 8'h50, 0, 'h300);
      put_ins(27, 8'h54, 0, 'h250);
      mem[30] = 8'hC7;
      put_word('h260, 24'hFFFFFF);
      mem['h300] = 8'h01;
      run_prog("R12");
      chk("R13 accumulator zero after reset", {8'h0, get_word('h260)}, 32'h0);
      chk("R11 R9 busy device then branches", {24'h0, mem['h250]}, 32'h01);
      begin
         int act = 0;
         for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            if (mem_we || dev_rd || dev_wr || !halt) act++;
         end
         chk("R12 idle after halt", act, 32'd0);
      end

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      #(8 * 190000);
      nchk++;
      nerr++;
      $display("FAIL watchdog expired (R12 halt never reached)");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

endmodule